// File: doc/BRIEF.md
# Display RAM column access controller

This block connects a byte-wide host port to a display memory of 132 columns by 9 pages. Each stored byte holds eight vertical pixels of one column in one page. The host presents a byte together with three controls: a data/command select, a read/write select and a one-cycle strobe.

Command bytes load the page pointer and the two halves of the column pointer. They also switch a read-modify-write mode on and off. Data bytes are written to, or read from, the location that the page and column pointers select. The column pointer steps forward after data accesses and never wraps back to zero.

Data reads pass through a holding latch, so each read returns the byte captured by the read before it. This means the first read after the pointer moves is a dummy read. A status read reports the current mode. Every access completes in the cycle of its strobe.

Top module: `disp_col_ctrl`

## Requirements
- R1: After reset the column pointer is 0, the page pointer is 0, the block is in normal mode, and both the read holding latch and `host_rdata` are 0x00.
- R2: A command byte 0x0n replaces only the low four bits of the column pointer with n. A command byte 0x1n replaces only the high four bits with n.
- R3: A command byte 0xBp with p from 0 to 8 selects page p. 0xB9 to 0xBF, and any command byte not listed in R2, R3 or R7, leave the pointers, the mode and the latch unchanged.
- R4: In normal mode, a data write stores the byte at (page, column) and then advances the column pointer by one.
- R5: A data read puts the latch contents on `host_rdata` from the next clock edge. On the same edge the latch is loaded from (page, column), and in normal mode the column pointer advances by one. Commands 0x0n, 0x1n, a valid 0xBp and 0xEE clear the latch to 0x00, so the first read after them returns 0x00.
- R6: The column pointer counts past 131 and saturates at 255 without rolling over. While it is above 131, data writes are discarded and data reads load 0x00 into the latch.
- R7: 0xE0 enters read-modify-write mode and records the column pointer; it is ignored if the mode is already on. In this mode data reads leave the column pointer unchanged and data writes still advance it. 0xEE leaves the mode and restores the recorded column; it is ignored in normal mode.
- R8: A status read (command select, read) drives `host_rdata` with bit 7 = busy (always 0), bit 6 = read-modify-write mode, and bits 5..0 = 0. It changes neither pointer. `host_rdata` changes only on read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stb | input | 1 | One-cycle access strobe |
| host_is_data | input | 1 | 1 = data access, 0 = command/status |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_wdata | input | 8 | Command or data byte from the host |
| host_rdata | output | 8 | Read result, registered |

## Verification
The hardest case to reach is the edge of the column range. The pointer has to be driven past column 131 and then up to 255, and the bench must show that it stays there instead of rolling over. A rollover would look exactly like saturation at the read port. So the stimulus loads column 254 and issues three writes in a row. It then rewinds to column 0 and reads that location to confirm the third write never arrived. A second hard case is a read-modify-write sequence that mixes a stale latch, a step of the pointer and a restore on exit. This is covered both by a directed sequence and by a long run of random commands, with a behavioural model compared on every clock.

// File: rtl/disp_col_ctrl.sv
module disp_col_ctrl #(
  parameter int COLS  = 132,
  parameter int PAGES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_stb,
  input  logic       host_is_data,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int DEPTH = COLS * PAGES;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(PAGES);

  logic [7:0]    ram [DEPTH];
  logic [7:0]    col, col_saved, rd_latch;
  logic [PW-1:0] page;
  logic          rmw;

  wire          in_range = int'(col) < COLS;
  wire [AW-1:0] addr     = AW'(int'(page) * COLS + int'(col));
  wire [7:0]    col_inc  = (col == 8'hFF) ? col : col + 8'd1;

  wire data_wr = host_stb &  host_is_data & ~host_rd;
  wire data_rd = host_stb &  host_is_data &  host_rd;
  wire cmd_wr  = host_stb & ~host_is_data & ~host_rd;
  wire stat_rd = host_stb & ~host_is_data &  host_rd;

  wire [3:0] op  = host_wdata[7:4];
  wire [3:0] arg = host_wdata[3:0];

  wire set_lo  = cmd_wr && op == 4'h0;
  wire set_hi  = cmd_wr && op == 4'h1;
  wire set_pg  = cmd_wr && op == 4'hB && int'(arg) < PAGES;
  wire rmw_on  = cmd_wr && host_wdata == 8'hE0 && !rmw;
  wire rmw_off = cmd_wr && host_wdata == 8'hEE && rmw;

  always_ff @(posedge clk)
    if (data_wr && in_range) ram[addr] <= host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col        <= '0;
      col_saved  <= '0;
      page       <= '0;
      rmw        <= 1'b0;
      rd_latch   <= '0;
      host_rdata <= '0;
    end else if (set_lo) begin
      col      <= {col[7:4], arg};
      rd_latch <= '0;
    end else if (set_hi) begin
      col      <= {arg, col[3:0]};
      rd_latch <= '0;
    end else if (set_pg) begin
      page     <= arg[PW-1:0];
      rd_latch <= '0;
    end else if (rmw_on) begin
      rmw       <= 1'b1;
      col_saved <= col;
    end else if (rmw_off) begin
      rmw      <= 1'b0;
      col      <= col_saved;
      rd_latch <= '0;
    end else if (data_wr) begin
      col <= col_inc;
    end else if (data_rd) begin
      host_rdata <= rd_latch;
      rd_latch   <= in_range ? ram[addr] : 8'h00;
      if (!rmw) col <= col_inc;
    end else if (stat_rd) begin
      host_rdata <= {1'b0, rmw, 6'b0};
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> col == 8'h00 && page == '0 && !rmw && host_rdata == 8'h00); // R1
  AST_COL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr || data_rd) && col != 8'h00 |=> col != 8'h00); // R6
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !in_range |=> rd_latch == 8'h00); // R6
  AST_PTR_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lo || set_hi || set_pg) |=> rd_latch == 8'h00); // R5
  AST_RMW_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && rmw |=> $stable(col)); // R7
  AST_RMW_EXIT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_off |=> col == $past(col_saved) && !rmw); // R7
  AST_STATUS_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> $stable(col) && $stable(page)); // R8
  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> host_rdata[5:0] == 6'b0 && !host_rdata[7]); // R8
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_rd || stat_rd) |=> $stable(host_rdata)); // R8
endmodule

// File: tb/test_disp_col_ctrl.sv
module test_disp_col_ctrl;
  logic clk = 0, rst_n = 0, stb = 0, is_data = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;

  disp_col_ctrl i_disp_col_ctrl (
    .clk(clk), .rst_n(rst_n), .host_stb(stb), .host_is_data(is_data),
    .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata));

  always #4 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  int m_mem [1188];
  int m_col = 0, m_page = 0, m_saved = 0, m_latch = 0, m_exp = 0;
  bit m_rmw = 0;
  string tag = "R1";

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic compare();
    vectors++;
    if (rdata !== m_exp[7:0]) begin
      fails++;
      $display("FAIL %s: host_rdata actual %02h expected %02h", tag, rdata, m_exp[7:0]);
    end
  endtask

  task automatic model(bit d, bit r, int b);
    int lo = b & 15, hi = (b >> 4) & 15;
    if (d && r) begin
      m_exp = m_latch;
      m_latch = (m_col < 132) ? m_mem[m_page*132 + m_col] : 0;
      if (!m_rmw && m_col < 255) m_col++;
    end else if (d) begin
      if (m_col < 132) m_mem[m_page*132 + m_col] = b;
      if (m_col < 255) m_col++;
    end else if (r) begin
      m_exp = m_rmw ? 8'h40 : 8'h00;
    end else if (hi == 0) begin
      m_col = (m_col & 8'hF0) | lo; m_latch = 0;
    end else if (hi == 1) begin
      m_col = (lo << 4) | (m_col & 15); m_latch = 0;
    end else if (hi == 11 && lo <= 8) begin
      m_page = lo; m_latch = 0;
    end else if (b == 8'hE0 && !m_rmw) begin
      m_rmw = 1; m_saved = m_col;
    end else if (b == 8'hEE && m_rmw) begin
      m_rmw = 0; m_col = m_saved; m_latch = 0;
    end
  endtask

  task automatic step(bit s, bit d, bit r, int b, string t);
    @(negedge clk);
    compare();
    tag = t;
    stb = s; is_data = d; rd = r; wdata = b[7:0];
    if (s) model(d, r, b);
  endtask

  task automatic cmd(int b, string t);  step(1, 0, 0, b, t); endtask
  task automatic wr(int b, string t);   step(1, 1, 0, b, t); endtask
  task automatic rdd(string t);         step(1, 1, 1, 0, t); endtask
  task automatic stat(string t);        step(1, 0, 1, 0, t); endtask
  task automatic setcol(int c, string t);
    cmd(c & 15, t); cmd(8'h10 | (c >> 4), t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, "R1");
    stat("R1");
    wr(8'hA5, "R1");
    setcol(0, "R1"); rdd("R5"); rdd("R1");
    // fill the whole memory
    for (int p = 0; p < 9; p++) begin
      cmd(8'hB0 | p, "R4"); setcol(0, "R4");
      for (int c = 0; c < 132; c++) wr((p * 37 + c * 5) & 255, "R4");
    end
    // nibble loads
    cmd(8'hB0, "R2"); cmd(8'h05, "R2"); cmd(8'h11, "R2"); cmd(8'h0A, "R2");
    wr(8'h3C, "R2"); wr(8'h3D, "R4");
    setcol(8'h1A, "R2"); rdd("R5"); rdd("R2"); rdd("R4"); rdd("R5");
    // page select, invalid page ignored
    cmd(8'hB3, "R3"); setcol(7, "R3"); wr(8'h77, "R3");
    cmd(8'hB9, "R3"); cmd(8'h5A, "R3"); setcol(7, "R3"); rdd("R5"); rdd("R3");
    // end of range, discard, saturation
    setcol(130, "R6"); wr(8'hE1, "R6"); wr(8'hE2, "R6"); wr(8'hE3, "R6");
    setcol(130, "R6"); rdd("R6"); rdd("R6"); rdd("R6"); rdd("R6"); rdd("R6");
    setcol(254, "R6"); wr(8'h91, "R6"); wr(8'h92, "R6"); wr(8'h93, "R6");
    rdd("R6"); rdd("R6");
    setcol(0, "R6"); rdd("R6"); rdd("R6");
    // read-modify-write
    cmd(8'hB1, "R7"); setcol(10, "R7"); wr(8'h11, "R7"); wr(8'h22, "R7");
    setcol(10, "R7"); cmd(8'hE0, "R7"); stat("R8");
    rdd("R7"); rdd("R7"); wr(8'h99, "R7"); rdd("R7"); rdd("R7");
    cmd(8'hE0, "R7");
    cmd(8'hEE, "R7"); stat("R8"); rdd("R7"); rdd("R7"); rdd("R7");
    cmd(8'hEE, "R7"); rdd("R7");
    stat("R8"); step(0, 0, 0, 0, "R8"); step(0, 0, 0, 0, "R8");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 99);
      if (k < 30)      wr($urandom_range(0, 255), "R4");
      else if (k < 60) rdd("R5");
      else if (k < 66) cmd($urandom_range(0, 15), "R2");
      else if (k < 72) cmd(8'h10 | $urandom_range(0, 8), "R2");
      else if (k < 74) cmd(8'h1F, "R6");
      else if (k < 79) cmd(8'hB0 | $urandom_range(0, 9), "R3");
      else if (k < 83) cmd(8'hE0, "R7");
      else if (k < 87) cmd(8'hEE, "R7");
      else if (k < 91) stat("R8");
      else if (k < 95) cmd($urandom_range(0, 255), "R3");
      else             step(0, 0, 0, 0, "R8");
    end
    step(0, 0, 0, 0, "R8");
    @(negedge clk); compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule